// File: doc/BRIEF.md
# eMMC Boot Partition Read Sequencer

This block takes an eMMC device that has already been enumerated and prepares it for block reads without going through the full initialisation. On a start pulse it deselects the card and ignores the outcome of that step. It then resets the host's command and data lines and waits for that reset to finish. Next it fetches the card-specific data register using a fixed relative card address. From two response words it decides whether the device is sector-addressed or byte-addressed. Finally it reselects the card and switches the device to boot partition 1.

Once ready, each read request programs the host controller for a single-operation DMA transfer of 512-byte blocks into a 32-bit destination address. It then issues a multi-block read. The block address is converted to a byte address when the device is byte-addressed. Commands go out on a command-request port with a valid/done handshake. Direct register accesses go out on a simple register master port with a request/acknowledge handshake.

Top module: `emmc_boot_loader`

## Requirements
- R1: A start pulse while idle or ready clears the error flag and ready, then issues command 7 with argument 0, a short response (cmd_rsp 2), CRC check and index check set. A failure reported on this command is ignored and the sequence continues.
- R2: After the deselect, the block writes byte 0x06 to register 0x2F (reg_size 0 = byte, 1 = halfword, 2 = word). It then reads byte 0x2F repeatedly until the read returns zero.
- R3: It then issues command 9 with argument 0x10000000, a 136-bit response (cmd_rsp 1), CRC check set and index check clear. After that it reads the words at 0x14 and 0x18.
- R4: The device is sector-addressed when (word 0x14 & 0xFFC00380) == 0xFFC00380 and (word 0x18 & 0x3) == 0x3. Otherwise it is byte-addressed.
- R5: After the card-data command, any command that fails sets a sticky error, clears ready and returns to idle with no further accesses. The error stays set until the next start.
- R6: The block reselects the card with command 7, argument 0x10000000 and a short response with CRC and index checks. It then issues command 6 with argument 0x03B30100, a short-with-busy response (cmd_rsp 3), CRC and index checks. When command 6 succeeds, ready goes high.
- R7: A read writes the word destination to 0x00, halfword 0x7200 to 0x04, and the block count as a halfword to 0x06, in that order.
- R8: Next it reads byte 0x28 and writes it back with bits 4:3 cleared. Then it reads byte 0x2A and writes it back with bit 0 cleared.
- R9: Finally the read issues command 18 with a short response, CRC, index and data flags set. The argument is the block address in sector mode, or the block address times 512 (truncated to 32 bits) in byte mode. rd_done pulses with rd_err equal to the command's failure flag.
- R10: A read request made when the block is not ready and waiting, or whose destination has any bit above bit 31 set, gets rd_done with rd_err on the next cycle. Such a request causes no register access and no command.
- R11: The command and register channels are never requested at the same time. Each request holds its fields stable until done or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence |
| ready | output | 1 | Bring-up finished, reads accepted |
| err | output | 1 | Sticky failure flag |
| rd_req | input | 1 | Read request pulse |
| rd_lba | input | LBA_W | Starting block address |
| rd_dst | input | DST_W | Destination memory address |
| rd_cnt | input | CNT_W | Number of 512-byte blocks |
| rd_done | output | 1 | Read finished or rejected (pulse) |
| rd_err | output | 1 | Read failed or rejected, valid with rd_done |
| cmd_valid | output | 1 | Command request |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp | output | 2 | Response kind: 0 none, 1 long, 2 short, 3 short with busy |
| cmd_crc_chk | output | 1 | Check response CRC |
| cmd_idx_chk | output | 1 | Check response index |
| cmd_data | output | 1 | Command carries a data transfer |
| cmd_done | input | 1 | Command finished (pulse) |
| cmd_err | input | 1 | Command failed, valid with cmd_done |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Write when high, read when low |
| reg_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_addr | output | 8 | Register byte offset |
| reg_wdata | output | 32 | Write data, low-aligned |
| reg_ack | input | 1 | Access finished (pulse) |
| reg_rdata | input | 32 | Read data, valid with reg_ack |

## Verification
The assertions assume the environment raises cmd_done only while cmd_valid is high and reg_ack only while reg_req is high. Both must be single-cycle pulses, and the two must not be asserted back to back for the same request. The bench's host and device models answer a request a fixed number of cycles after seeing it, for one cycle only. Read requests are single-cycle pulses driven on the falling edge, so the handshake and rejection properties only ever see legal sequences.

// File: rtl/emmc_ldr_pkg.sv
package emmc_ldr_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_DESEL, S_RSTW, S_RSTP, S_CSD, S_CSD0, S_CSD1, S_SEL, S_SW,
    S_RDY, S_DMA, S_BSZ, S_BCNT, S_HCR, S_HCW, S_BGR, S_BGW, S_RDCMD
  } ldr_state_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  localparam logic [1:0] RSP_LONG  = 2'd1;
  localparam logic [1:0] RSP_SHORT = 2'd2;
  localparam logic [1:0] RSP_BUSY  = 2'd3;

  localparam logic [7:0] A_DMA    = 8'h00;
  localparam logic [7:0] A_BSZ    = 8'h04;
  localparam logic [7:0] A_BCNT   = 8'h06;
  localparam logic [7:0] A_RSP_LO = 8'h14;
  localparam logic [7:0] A_RSP_HI = 8'h18;
  localparam logic [7:0] A_HCTL   = 8'h28;
  localparam logic [7:0] A_GAP    = 8'h2A;
  localparam logic [7:0] A_SRST   = 8'h2F;

  localparam logic [7:0] LINE_RST_VAL = 8'h06;
  localparam logic [7:0] DMA_SEL_MASK = 8'h18;
  localparam logic [7:0] GAP_STOP_BIT = 8'h01;

  localparam logic [5:0] C_SWITCH = 6'd6;
  localparam logic [5:0] C_SELECT = 6'd7;
  localparam logic [5:0] C_CARDDATA = 6'd9;
  localparam logic [5:0] C_MREAD = 6'd18;

endpackage

// File: rtl/emmc_csd_addr_mode.sv
module emmc_csd_addr_mode #(
  parameter logic [31:0] LO_MASK = 32'hFFC00380,
  parameter logic [31:0] HI_MASK = 32'h00000003
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cap_lo,
  input  logic        cap_hi,
  input  logic [31:0] word,
  output logic        sector_mode
);
  logic lo_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_ok       <= 1'b0;
      sector_mode <= 1'b0;
    end else begin
      if (cap_lo) lo_ok <= ((word & LO_MASK) == LO_MASK);
      if (cap_hi) sector_mode <= lo_ok && ((word & HI_MASK) == HI_MASK);
    end
  end
endmodule

// File: rtl/emmc_rd_arg.sv
module emmc_rd_arg #(
  parameter int LBA_W   = 32,
  parameter int BLK_LOG = 9
) (
  input  logic [LBA_W-1:0] lba,
  input  logic             sector_mode,
  output logic [31:0]      arg
);
  localparam int EXT_W = (LBA_W > 32) ? LBA_W : 32;
  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = EXT_W'(lba);
    arg = sector_mode ? ext[31:0] : 32'(ext << BLK_LOG);
  end
endmodule

// File: rtl/emmc_boot_loader.sv
module emmc_boot_loader
  import emmc_ldr_pkg::*;
#(
  parameter int          LBA_W      = 32,
  parameter int          DST_W      = 64,
  parameter int          CNT_W      = 16,
  parameter logic [15:0] RCA        = 16'h1000,
  parameter logic [7:0]  BOOT_PART  = 8'd1,
  parameter logic [7:0]  PART_INDEX = 8'd179,
  parameter logic [1:0]  ACCESS_WR  = 2'd3,
  parameter logic [2:0]  DMA_BOUND  = 3'd7,
  parameter int          BLK_LOG    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             ready,
  output logic             err,
  input  logic             rd_req,
  input  logic [LBA_W-1:0] rd_lba,
  input  logic [DST_W-1:0] rd_dst,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             rd_done,
  output logic             rd_err,
  output logic             cmd_valid,
  output logic [5:0]       cmd_idx,
  output logic [31:0]      cmd_arg,
  output logic [1:0]       cmd_rsp,
  output logic             cmd_crc_chk,
  output logic             cmd_idx_chk,
  output logic             cmd_data,
  input  logic             cmd_done,
  input  logic             cmd_err,
  output logic             reg_req,
  output logic             reg_we,
  output logic [1:0]       reg_size,
  output logic [7:0]       reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata
);
  localparam logic [11:0] BLK_BYTES = 12'(1 << BLK_LOG);
  localparam logic [31:0] RCA_ARG   = {RCA, 16'h0000};
  localparam logic [31:0] PART_ARG  = {6'd0, ACCESS_WR, PART_INDEX, BOOT_PART, 8'h00};
  localparam logic [31:0] BSZ_VAL   = {16'h0000, 1'b0, DMA_BOUND, BLK_BYTES};

  ldr_state_e       st, reg_nx, cmd_nx;
  logic             is_reg, is_cmd, dst_ok, sector_mode, reg_fin;
  logic [LBA_W-1:0] lba_q;
  logic [31:0]      dst_q, rd_arg_w;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       rmw_q;
  logic             op_we;
  logic [1:0]       op_size;
  logic [7:0]       op_addr;
  logic [31:0]      op_wdata, op_arg;
  logic [5:0]       op_idx;
  logic [1:0]       op_rsp;
  logic             op_crc, op_ichk, op_data;

  generate
    if (DST_W > 32) begin : g_wide_dst
      assign dst_ok = ~|rd_dst[DST_W-1:32];
    end else begin : g_narrow_dst
      assign dst_ok = 1'b1;
    end
  endgenerate

  assign reg_fin = reg_req && reg_ack;

  emmc_csd_addr_mode u_mode (
    .clk(clk), .rst(rst),
    .cap_lo(reg_fin && st == S_CSD0),
    .cap_hi(reg_fin && st == S_CSD1),
    .word(reg_rdata), .sector_mode(sector_mode)
  );

  emmc_rd_arg #(.LBA_W(LBA_W), .BLK_LOG(BLK_LOG)) u_arg (
    .lba(lba_q), .sector_mode(sector_mode), .arg(rd_arg_w)
  );

  always_comb begin
    is_reg   = st inside {S_RSTW, S_RSTP, S_CSD0, S_CSD1, S_DMA, S_BSZ,
                          S_BCNT, S_HCR, S_HCW, S_BGR, S_BGW};
    is_cmd   = st inside {S_DESEL, S_CSD, S_SEL, S_SW, S_RDCMD};
    op_we    = 1'b0;
    op_size  = SZ_B;
    op_addr  = 8'h00;
    op_wdata = 32'h0;
    reg_nx   = S_IDLE;
    op_idx   = C_SELECT;
    op_arg   = 32'h0;
    op_rsp   = RSP_SHORT;
    op_crc   = 1'b1;
    op_ichk  = 1'b1;
    op_data  = 1'b0;
    cmd_nx   = S_IDLE;
    case (st)
      S_RSTW:  begin op_we = 1'b1; op_addr = A_SRST; op_wdata = 32'(LINE_RST_VAL); reg_nx = S_RSTP; end
      S_RSTP:  begin op_addr = A_SRST; reg_nx = (reg_rdata[7:0] == 8'h00) ? S_CSD : S_RSTP; end
      S_CSD0:  begin op_size = SZ_W; op_addr = A_RSP_LO; reg_nx = S_CSD1; end
      S_CSD1:  begin op_size = SZ_W; op_addr = A_RSP_HI; reg_nx = S_SEL; end
      S_DMA:   begin op_we = 1'b1; op_size = SZ_W; op_addr = A_DMA; op_wdata = dst_q; reg_nx = S_BSZ; end
      S_BSZ:   begin op_we = 1'b1; op_size = SZ_H; op_addr = A_BSZ; op_wdata = BSZ_VAL; reg_nx = S_BCNT; end
      S_BCNT:  begin op_we = 1'b1; op_size = SZ_H; op_addr = A_BCNT; op_wdata = 32'(cnt_q); reg_nx = S_HCR; end
      S_HCR:   begin op_addr = A_HCTL; reg_nx = S_HCW; end
      S_HCW:   begin op_we = 1'b1; op_addr = A_HCTL; op_wdata = 32'(rmw_q & ~DMA_SEL_MASK); reg_nx = S_BGR; end
      S_BGR:   begin op_addr = A_GAP; reg_nx = S_BGW; end
      S_BGW:   begin op_we = 1'b1; op_addr = A_GAP; op_wdata = 32'(rmw_q & ~GAP_STOP_BIT); reg_nx = S_RDCMD; end
      S_DESEL: cmd_nx = S_RSTW;
      S_CSD:   begin op_idx = C_CARDDATA; op_arg = RCA_ARG; op_rsp = RSP_LONG; op_ichk = 1'b0; cmd_nx = S_CSD0; end
      S_SEL:   begin op_arg = RCA_ARG; cmd_nx = S_SW; end
      S_SW:    begin op_idx = C_SWITCH; op_arg = PART_ARG; op_rsp = RSP_BUSY; cmd_nx = S_RDY; end
      S_RDCMD: begin op_idx = C_MREAD; op_arg = rd_arg_w; op_data = 1'b1; cmd_nx = S_RDY; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ready <= 1'b0; err <= 1'b0; rd_done <= 1'b0; rd_err <= 1'b0;
      cmd_valid <= 1'b0; cmd_idx <= 6'd0; cmd_arg <= 32'h0; cmd_rsp <= 2'd0;
      cmd_crc_chk <= 1'b0; cmd_idx_chk <= 1'b0; cmd_data <= 1'b0;
      reg_req <= 1'b0; reg_we <= 1'b0; reg_size <= 2'd0; reg_addr <= 8'h00; reg_wdata <= 32'h0;
      lba_q <= '0; dst_q <= 32'h0; cnt_q <= '0; rmw_q <= 8'h00;
    end else begin
      rd_done <= 1'b0;
      if (rd_req) begin
        if (st == S_RDY && !start && dst_ok) begin
          lba_q <= rd_lba; dst_q <= rd_dst[31:0]; cnt_q <= rd_cnt; st <= S_DMA;
        end else begin
          rd_done <= 1'b1; rd_err <= 1'b1;
        end
      end
      if (start && (st == S_IDLE || st == S_RDY)) begin
        err <= 1'b0; ready <= 1'b0; st <= S_DESEL;
      end
      if (is_reg) begin
        if (!reg_req) begin
          reg_req <= 1'b1; reg_we <= op_we; reg_size <= op_size;
          reg_addr <= op_addr; reg_wdata <= op_wdata;
        end else if (reg_ack) begin
          reg_req <= 1'b0;
          if (st == S_HCR || st == S_BGR) rmw_q <= reg_rdata[7:0];
          st <= reg_nx;
        end
      end
      if (is_cmd) begin
        if (!cmd_valid) begin
          cmd_valid <= 1'b1; cmd_idx <= op_idx; cmd_arg <= op_arg; cmd_rsp <= op_rsp;
          cmd_crc_chk <= op_crc; cmd_idx_chk <= op_ichk; cmd_data <= op_data;
        end else if (cmd_done) begin
          cmd_valid <= 1'b0;
          if (st == S_RDCMD) begin
            rd_done <= 1'b1; rd_err <= cmd_err;
          end
          if (cmd_err && st != S_DESEL) begin
            err <= 1'b1; ready <= 1'b0; st <= S_IDLE;
          end else begin
            if (st == S_SW) ready <= 1'b1;
            st <= cmd_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/emmc_boot_loader_chk.sv
module emmc_boot_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        err,
  input logic        rd_req,
  input logic        rd_done,
  input logic        rd_err,
  input logic        cmd_valid,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic        cmd_data,
  input logic        cmd_done,
  input logic        reg_req,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_ack
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_idx) && $stable(cmd_arg)); // R11
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_we)); // R11
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && reg_req)); // R11
  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ready |-> !err); // R5
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_req && !ready |=> rd_done && rd_err); // R10
  AST_DATA_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_data |-> cmd_idx == 6'd18 && ready); // R9
endmodule

bind emmc_boot_loader emmc_boot_loader_chk u_chk (
  .clk(clk), .rst(rst), .ready(ready), .err(err), .rd_req(rd_req),
  .rd_done(rd_done), .rd_err(rd_err), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
  .cmd_arg(cmd_arg), .cmd_data(cmd_data), .cmd_done(cmd_done), .reg_req(reg_req),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack)
);

// File: tb/sim_emmc_boot_loader.sv
module sim_emmc_boot_loader;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, ready, err, rd_req, rd_done, rd_err;
  logic [31:0] rd_lba;
  logic [63:0] rd_dst;
  logic [15:0] rd_cnt;
  logic cmd_valid, cmd_crc_chk, cmd_idx_chk, cmd_data, cmd_done, cmd_err;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg;
  logic [1:0] cmd_rsp;
  logic reg_req, reg_we, reg_ack;
  logic [1:0] reg_size;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  emmc_boot_loader u0 (.*);

  int n_vec = 0, n_bad = 0;
  int poll_init = 0, poll_left, cmd_timer, ev_n, done_cnt, overlap;
  bit fail_desel, fail_csd, fail_sel, fail_sw, fail_rd;
  logic [31:0] csd_lo, csd_hi;
  logic done_err_q;
  logic [7:0] rmem [0:255];
  int ev_kind [0:63];
  logic [31:0] ev_a [0:63], ev_b [0:63], ev_c [0:63];

  // host register and device models
  always @(posedge clk) begin
    if (rst) begin
      reg_ack <= 1'b0; cmd_done <= 1'b0; cmd_err <= 1'b0; cmd_timer <= 0; ev_n <= 0;
      reg_rdata <= 32'h0; poll_left <= 0; done_cnt <= 0; overlap <= 0;
      for (int k = 0; k < 256; k++) rmem[k] <= 8'hFF;
    end else begin
      if (rd_done) begin done_cnt <= done_cnt + 1; done_err_q <= rd_err; end
      if (cmd_valid && reg_req) overlap <= overlap + 1;
      reg_ack <= 1'b0;
      if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        ev_kind[ev_n] <= 1; ev_a[ev_n] <= 32'(reg_addr);
        ev_b[ev_n] <= reg_we ? reg_wdata : 32'h0; ev_c[ev_n] <= {29'd0, reg_we, reg_size};
        ev_n <= ev_n + 1;
        if (reg_we) begin
          for (int k = 0; k < (1 << reg_size); k++) rmem[8'(reg_addr + 8'(k))] <= reg_wdata[8*k +: 8];
          if (reg_addr == 8'h2F) poll_left <= poll_init;
        end else if (reg_addr == 8'h2F) begin
          reg_rdata <= (poll_left != 0) ? 32'h6 : 32'h0;
          if (poll_left != 0) poll_left <= poll_left - 1;
        end else if (reg_addr == 8'h14) reg_rdata <= csd_lo;
        else if (reg_addr == 8'h18) reg_rdata <= csd_hi;
        else reg_rdata <= {rmem[8'(reg_addr+3)], rmem[8'(reg_addr+2)], rmem[8'(reg_addr+1)], rmem[reg_addr]};
      end
      cmd_done <= 1'b0;
      if (cmd_valid && !cmd_done) begin
        if (cmd_timer == 2) begin
          cmd_timer <= 0; cmd_done <= 1'b1;
          cmd_err <= (cmd_idx == 6'd7 && cmd_arg == 0) ? fail_desel :
                     (cmd_idx == 6'd9) ? fail_csd : (cmd_idx == 6'd7) ? fail_sel :
                     (cmd_idx == 6'd6) ? fail_sw : fail_rd;
          ev_kind[ev_n] <= 2; ev_a[ev_n] <= 32'(cmd_idx); ev_b[ev_n] <= cmd_arg;
          ev_c[ev_n] <= {27'd0, cmd_rsp, cmd_crc_chk, cmd_idx_chk, cmd_data};
          ev_n <= ev_n + 1;
        end else cmd_timer <= cmd_timer + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_ev(input string tag, input int i, input int kind,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    chk({tag, " kind"}, 32'(ev_kind[i]), 32'(kind));
    chk({tag, " field a"}, ev_a[i], a);
    chk({tag, " field b"}, ev_b[i], b);
    chk({tag, " field c"}, ev_c[i], c);
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_init(input logic [31:0] lo, input logic [31:0] hi, input int polls,
                         input bit fd, input bit fc, input bit fs, input bit fw);
    do_reset();
    csd_lo = lo; csd_hi = hi; poll_init = polls;
    fail_desel = fd; fail_csd = fc; fail_sel = fs; fail_sw = fw; fail_rd = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!(ready || err)) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_read(input logic [31:0] lba, input logic [63:0] dst, input logic [15:0] cnt);
    int c0;
    c0 = done_cnt;
    rd_lba = lba; rd_dst = dst; rd_cnt = cnt; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (done_cnt == c0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 reset ready", 32'(ready), 0);
    chk("R5 reset err", 32'(err), 0);
    chk("R11 reset cmd_valid", 32'(cmd_valid), 0);
    chk("R11 reset reg_req", 32'(reg_req), 0);
  endtask

  task automatic t_reject_idle();
    int c0;
    c0 = done_cnt;
    do_read(32'd4, 64'h1000, 16'd1);
    chk("R10 idle reject done", 32'(done_cnt - c0), 1);
    chk("R10 idle reject err", 32'(done_err_q), 1);
    chk("R10 idle reject no access", 32'(ev_n), 0);
  endtask

  task automatic t_init_sector();
    do_init(32'hFFC00380, 32'h3, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 ready after init", 32'(ready), 1);
    chk("R1 deselect failure ignored err", 32'(err), 0);
    chk("R6 event count", 32'(ev_n), 10);
    chk_ev("R1 deselect", 0, 2, 7, 0, 32'h16);
    chk_ev("R2 line reset write", 1, 1, 32'h2F, 32'h6, 32'h4);
    chk_ev("R2 poll 1", 2, 1, 32'h2F, 0, 0);
    chk_ev("R2 poll 2", 3, 1, 32'h2F, 0, 0);
    chk_ev("R2 poll 3", 4, 1, 32'h2F, 0, 0);
    chk_ev("R3 card data cmd", 5, 2, 9, 32'h10000000, 32'h0C);
    chk_ev("R3 word lo", 6, 1, 32'h14, 0, 32'h2);
    chk_ev("R3 word hi", 7, 1, 32'h18, 0, 32'h2);
    chk_ev("R6 reselect", 8, 2, 7, 32'h10000000, 32'h16);
    chk_ev("R6 partition switch", 9, 2, 6, 32'h03B30100, 32'h1E);
  endtask

  task automatic t_read_sector();
    int m;
    m = ev_n;
    do_read(32'd5, 64'h0000_0000_8000_1000, 16'd3);
    chk("R9 read ok", 32'(done_err_q), 0);
    chk("R9 read event count", 32'(ev_n - m), 8);
    chk_ev("R7 dma addr", m, 1, 32'h00, 32'h80001000, 32'h6);
    chk_ev("R7 block size", m+1, 1, 32'h04, 32'h7200, 32'h5);
    chk_ev("R7 block count", m+2, 1, 32'h06, 32'h3, 32'h5);
    chk_ev("R8 host ctl read", m+3, 1, 32'h28, 0, 0);
    chk_ev("R8 host ctl write", m+4, 1, 32'h28, 32'hE7, 32'h4);
    chk_ev("R8 gap read", m+5, 1, 32'h2A, 0, 0);
    chk_ev("R8 gap write", m+6, 1, 32'h2A, 32'hFE, 32'h4);
    chk_ev("R9 multi read cmd sector", m+7, 2, 18, 32'd5, 32'h17);
  endtask

  task automatic t_reject_wide_dst();
    int m;
    m = ev_n;
    do_read(32'd1, 64'h1_0000_0000, 16'd1);
    chk("R10 wide dst reject", 32'(done_err_q), 1);
    chk("R10 wide dst no access", 32'(ev_n - m), 0);
    chk("R10 still ready", 32'(ready), 1);
  endtask

  task automatic t_byte_modes();
    do_init(32'hFFC00300, 32'h3, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 lo mismatch ready", 32'(ready), 1);
    do_read(32'd5, 64'h2000, 16'd1);
    chk("R4 lo mismatch byte arg", ev_b[ev_n-1], 32'hA00);
    do_init(32'hFFC00380, 32'h1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_read(32'h0080_0001, 64'h2000, 16'd1);
    chk("R9 byte arg truncation", ev_b[ev_n-1], 32'h200);
    chk("R9 byte read ok", 32'(done_err_q), 0);
  endtask

  task automatic t_read_fail();
    do_init(32'hFFC00380, 32'h3, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    fail_rd = 1'b1;
    do_read(32'd7, 64'h3000, 16'd2);
    chk("R9 read fail rd_err", 32'(done_err_q), 1);
    chk("R5 read fail sticky err", 32'(err), 1);
    chk("R5 read fail ready low", 32'(ready), 0);
  endtask

  task automatic t_init_fail();
    int m;
    do_init(32'hFFC00380, 32'h3, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 card data fail err", 32'(err), 1);
    chk("R5 card data fail stops", 32'(ev_n), 4);
    do_init(32'hFFC00380, 32'h3, 0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 reselect fail err", 32'(err), 1);
    chk("R5 reselect fail stops", 32'(ev_n), 7);
    do_init(32'hFFC00380, 32'h3, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 switch fail err", 32'(err), 1);
    chk("R6 switch fail no ready", 32'(ready), 0);
    m = ev_n;
    do_read(32'd1, 64'h10, 16'd1);
    chk("R10 reject after error", 32'(done_err_q), 1);
    chk("R10 no access after error", 32'(ev_n - m), 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    fail_sw = 1'b0;
    while (!(ready || err)) @(negedge clk);
    chk("R1 restart clears err", 32'(err), 0);
    chk("R1 restart ready", 32'(ready), 1);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst = 1'b1; start = 1'b0; rd_req = 1'b0; rd_lba = 0; rd_dst = 0; rd_cnt = 0;
    csd_lo = 0; csd_hi = 0; done_err_q = 1'b0;
    fail_desel = 0; fail_csd = 0; fail_sel = 0; fail_sw = 0; fail_rd = 0;
    t_reset_state();
    t_reject_idle();
    t_init_sector();
    t_read_sector();
    t_reject_wide_dst();
    t_byte_modes();
    t_read_fail();
    t_init_fail();
    chk("R11 channels never overlap", 32'(overlap), 0);
    finish_up();
  end
endmodule